// File: doc/BRIEF.md
# CAN Bit Destuffer

This block sits between a CAN bit sampler and the frame parser. Each sampled bus bit arrives with a one-cycle strobe. The block keeps a short record of the current run of equal raw bits. When five equal bits have been seen, the next raw bit must have the opposite value. That bit is a stuff bit: it is removed from the stream and is not forwarded. Every other raw bit is forwarded to the parser one cycle later, with its own strobe.

The parser controls the removal of stuff bits. From the CRC delimiter onward, which covers the ACK slot, the ACK delimiter and the end-of-frame field, it holds `stuff_off` high. In that state every raw bit passes through unchanged. A start-of-frame pulse clears the run record, so a new frame does not inherit the run of the previous one. A sixth equal bit while removal is active is a stuffing violation. It produces a one-cycle error pulse.

Top module: `can_unstuff`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `dat_vld` and `stuff_err` are low.
- R2: The first raw bit after a `sof` pulse is always forwarded, whatever the bits before it were. A `sof` in the same cycle as a strobe applies to that bit.
- R3: With `stuff_off` low, a raw bit that follows five equal raw bits and has the opposite value is dropped. It raises neither `dat_vld` nor `stuff_err`.
- R4: A dropped stuff bit counts as the first bit of the next run. For example, 0,0,0,0,0,1(stuff),1,1,1,1 makes a following 0 a stuff bit as well.
- R5: With `stuff_off` low, a raw bit that equals the five equal bits before it raises `stuff_err` for exactly one cycle. That bit is not forwarded, and the run record is cleared.
- R6: With `stuff_off` high, every raw bit is forwarded and `stuff_err` stays low.
- R7: A forwarded bit appears on `dat_bit` with `dat_vld` high for exactly one cycle. This happens in the cycle after its `raw_vld` strobe, and `dat_bit` equals the raw value.
- R8: Cycles without `raw_vld` produce no output pulse and leave the run record unchanged.
- R9: A `sof` pulse in the middle of a run discards the run. Four zeros, then `sof`, then five more zeros, then a one gives forwarded data for every zero and drops the one as a stuff bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start of frame; clears the run record |
| raw_vld | input | 1 | Strobe for a sampled raw bit |
| raw_bit | input | 1 | Sampled raw bit value (0 = dominant) |
| stuff_off | input | 1 | High while the parser is in the unstuffed tail of the frame |
| dat_vld | output | 1 | Strobe for a forwarded bit |
| dat_bit | output | 1 | Forwarded bit value |
| stuff_err | output | 1 | One-cycle pulse on a stuffing violation |

## Verification
The bench sweeps every 10-bit raw pattern twice: once with removal active for the whole frame, and once with `stuff_off` raised from the sixth bit on. Idle cycles are inserted between bits. This catches a design that counts the stuff bit into the wrong run, because it would then drop or flag bits at the wrong positions. It also catches a design that keeps filtering after `stuff_off`, because it would lose tail bits. A design that lets idle cycles advance the run would report false violations.

Directed runs cover a `sof` arriving mid-run. A design that kept the old history there would flag an error instead of dropping a stuff bit. They also cover two stuff bits in a row and the clearing of the run record after an error.

// File: rtl/can_unstuff_pkg.sv
package can_unstuff_pkg;

  // Classification of one raw bit.
  typedef enum logic [1:0] {
    CLS_DATA  = 2'd0,
    CLS_STUFF = 2'd1,
    CLS_ERR   = 2'd2
  } bit_cls_e;

endpackage

// File: rtl/can_unstuff_hist.sv
// Tracks the length and value of the current run of equal raw bits.
module can_unstuff_hist
  import can_unstuff_pkg::*;
#(
  parameter int RUN_LEN = 5,
  localparam int CNT_W = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof,
  input  logic             raw_vld,
  input  logic             raw_bit,
  input  bit_cls_e         cls,
  output logic [CNT_W-1:0] run_cnt,
  output logic             run_val
);

  logic [CNT_W-1:0] cnt_q;
  logic             val_q;
  logic [CNT_W-1:0] cnt_d;
  logic             val_d;

  // A start of frame in the same cycle hides the stored run.
  assign run_cnt = sof ? '0 : cnt_q;
  assign run_val = val_q;

  always_comb begin
    cnt_d = run_cnt;
    val_d = val_q;
    if (raw_vld) begin
      unique case (cls)
        CLS_STUFF: begin
          cnt_d = CNT_W'(1);
          val_d = raw_bit;
        end
        CLS_ERR: begin
          cnt_d = '0;
        end
        default: begin
          if (run_cnt == '0 || raw_bit != val_q)
            cnt_d = CNT_W'(1);
          else if (run_cnt < CNT_W'(RUN_LEN))
            cnt_d = run_cnt + CNT_W'(1);
          else
            cnt_d = run_cnt;
          val_d = raw_bit;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      val_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      val_q <= val_d;
    end
  end

endmodule

// File: rtl/can_unstuff_class.sv
// Decides whether the current raw bit is data, a stuff bit or a violation.
module can_unstuff_class
  import can_unstuff_pkg::*;
#(
  parameter int RUN_LEN = 5,
  localparam int CNT_W = $clog2(RUN_LEN + 1)
) (
  input  logic [CNT_W-1:0] run_cnt,
  input  logic             run_val,
  input  logic             raw_bit,
  input  logic             stuff_off,
  output bit_cls_e         cls
);

  always_comb begin
    if (stuff_off || run_cnt < CNT_W'(RUN_LEN))
      cls = CLS_DATA;
    else if (raw_bit != run_val)
      cls = CLS_STUFF;
    else
      cls = CLS_ERR;
  end

endmodule

// File: rtl/can_unstuff_oreg.sv
// Registered output stage.
module can_unstuff_oreg
  import can_unstuff_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     raw_vld,
  input  logic     raw_bit,
  input  bit_cls_e cls,
  output logic     dat_vld,
  output logic     dat_bit,
  output logic     stuff_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_vld   <= 1'b0;
      dat_bit   <= 1'b1;
      stuff_err <= 1'b0;
    end else begin
      dat_vld   <= raw_vld && (cls == CLS_DATA);
      stuff_err <= raw_vld && (cls == CLS_ERR);
      if (raw_vld && cls == CLS_DATA)
        dat_bit <= raw_bit;
    end
  end

endmodule

// File: rtl/can_unstuff.sv
module can_unstuff
  import can_unstuff_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic sof,
  input  logic raw_vld,
  input  logic raw_bit,
  input  logic stuff_off,
  output logic dat_vld,
  output logic dat_bit,
  output logic stuff_err
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic [CNT_W-1:0] run_cnt;
  logic             run_val;
  bit_cls_e         cls;

  can_unstuff_hist #(.RUN_LEN(RUN_LEN)) i_hist (
    .clk     (clk),
    .rst     (rst),
    .sof     (sof),
    .raw_vld (raw_vld),
    .raw_bit (raw_bit),
    .cls     (cls),
    .run_cnt (run_cnt),
    .run_val (run_val)
  );

  can_unstuff_class #(.RUN_LEN(RUN_LEN)) i_class (
    .run_cnt   (run_cnt),
    .run_val   (run_val),
    .raw_bit   (raw_bit),
    .stuff_off (stuff_off),
    .cls       (cls)
  );

  can_unstuff_oreg i_oreg (
    .clk       (clk),
    .rst       (rst),
    .raw_vld   (raw_vld),
    .raw_bit   (raw_bit),
    .cls       (cls),
    .dat_vld   (dat_vld),
    .dat_bit   (dat_bit),
    .stuff_err (stuff_err)
  );

endmodule

// File: rtl/can_unstuff_chk.sv
module can_unstuff_chk (
  input logic clk,
  input logic rst,
  input logic sof,
  input logic raw_vld,
  input logic raw_bit,
  input logic stuff_off,
  input logic dat_vld,
  input logic dat_bit,
  input logic stuff_err
);

  // R1: outputs quiet in the cycle after a reset cycle
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!dat_vld && !stuff_err));

  // R2: first bit of a frame is forwarded
  a_r2_sof_forwards: assert property (@(posedge clk) disable iff (rst)
    (sof && raw_vld) |=> dat_vld);

  // R5: an error pulse only follows a strobe with removal active
  a_r5_err_source: assert property (@(posedge clk) disable iff (rst)
    stuff_err |-> $past(raw_vld && !stuff_off));

  // R5: an error pulse never coincides with forwarded data
  a_r5_err_excl: assert property (@(posedge clk) disable iff (rst)
    !(stuff_err && dat_vld));

  // R6: with removal off every bit passes unchanged
  a_r6_passthru: assert property (@(posedge clk) disable iff (rst)
    (raw_vld && stuff_off) |=> (dat_vld && !stuff_err && dat_bit == $past(raw_bit)));

  // R7: forwarded value equals the raw value
  a_r7_value: assert property (@(posedge clk) disable iff (rst)
    raw_vld |=> (!dat_vld || dat_bit == $past(raw_bit)));

  // R8: no strobe, no output
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !raw_vld |=> (!dat_vld && !stuff_err));

endmodule

bind can_unstuff can_unstuff_chk i_can_unstuff_chk (
  .clk       (clk),
  .rst       (rst),
  .sof       (sof),
  .raw_vld   (raw_vld),
  .raw_bit   (raw_bit),
  .stuff_off (stuff_off),
  .dat_vld   (dat_vld),
  .dat_bit   (dat_bit),
  .stuff_err (stuff_err)
);

// File: tb/test_can_unstuff.sv
module test_can_unstuff;

  logic clk = 1'b0;
  logic rst;
  logic sof;
  logic raw_vld;
  logic raw_bit;
  logic stuff_off;
  logic dat_vld;
  logic dat_bit;
  logic stuff_err;

  int n_tests = 0;
  int n_fail  = 0;

  // Bench model state, derived from the requirements.
  int m_cnt  = 0;
  bit m_last = 1'b1;

  always #2 clk = ~clk;

  can_unstuff #(.RUN_LEN(5)) i_can_unstuff (
    .clk       (clk),
    .rst       (rst),
    .sof       (sof),
    .raw_vld   (raw_vld),
    .raw_bit   (raw_bit),
    .stuff_off (stuff_off),
    .dat_vld   (dat_vld),
    .dat_bit   (dat_bit),
    .stuff_err (stuff_err)
  );

  task automatic chk(input string req, input logic act_v, act_b, act_e,
                     input logic exp_v, exp_b, exp_e);
    n_tests++;
    if (act_v !== exp_v || act_e !== exp_e || (exp_v && act_b !== exp_b)) begin
      n_fail++;
      $display("FAIL %s: vld/bit/err actual %b/%b/%b expected %b/%b/%b",
               req, act_v, act_b, act_e, exp_v, exp_b, exp_e);
    end
  endtask

  // Send one raw bit and check the output one cycle later (R7 latency).
  task automatic send(input logic b, input logic s, input logic off, input string tag);
    int    cnt;
    logic  ev, ee;
    string req;
    cnt = s ? 0 : m_cnt;
    ev = 1'b1; ee = 1'b0;
    req = off ? "R6" : "R7";
    if (!off && cnt >= 5) begin
      if (b != m_last) begin
        ev = 1'b0; req = "R3"; cnt = 1; m_last = b;
      end else begin
        ev = 1'b0; ee = 1'b1; req = "R5"; cnt = 0;
      end
    end else begin
      if (cnt == 0 || b != m_last) cnt = 1;
      else if (cnt < 5) cnt = cnt + 1;
      m_last = b;
    end
    m_cnt = cnt;
    if (tag != "") req = tag;
    raw_vld = 1'b1; raw_bit = b; sof = s; stuff_off = off;
    @(negedge clk);
    raw_vld = 1'b0; sof = 1'b0;
    chk(req, dat_vld, dat_bit, stuff_err, ev, b, ee);
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk("R8", dat_vld, dat_bit, stuff_err, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; sof = 1'b0; raw_vld = 1'b0; raw_bit = 1'b1; stuff_off = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", dat_vld, dat_bit, stuff_err, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", dat_vld, dat_bit, stuff_err, 1'b0, 1'b0, 1'b0);

    // R4: a stuff bit opens the next run
    send(1'b0, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 4; i++) send(1'b0, 1'b0, 1'b0, "R4");
    send(1'b1, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 4; i++) send(1'b1, 1'b0, 1'b0, "R4");
    send(1'b0, 1'b0, 1'b0, "R4");

    // R9: sof mid-run discards the history
    send(1'b0, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 3; i++) send(1'b0, 1'b0, 1'b0, "R9");
    send(1'b0, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 4; i++) send(1'b0, 1'b0, 1'b0, "R9");
    send(1'b1, 1'b0, 1'b0, "R9");

    // R5: violation, then history cleared so the next 5 equal bits are data
    send(1'b1, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 4; i++) send(1'b1, 1'b0, 1'b0, "");
    send(1'b1, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 5; i++) send(1'b1, 1'b0, 1'b0, "R5");
    idle_chk();

    // Exhaustive sweep: every 10-bit pattern, removal on throughout or off from bit 5.
    for (int mode = 0; mode < 2; mode++) begin
      for (int pat = 0; pat < 1024; pat++) begin
        for (int k = 0; k < 10; k++) begin
          send(pat[9-k], (k == 0), (mode == 1 && k >= 5), "");
          if (pat[k] && k < 9) idle_chk();
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule